// File: doc/BRIEF.md
# Network DMA FIFO with Threshold Request Control

This block is a small byte FIFO that sits between the byte stream of a network port and the DMA engine of a local buffer memory. It works in one of two directions. In receive, network bytes enter the FIFO and the memory side drains them. In transmit, the memory side fills the FIFO and the network side drains it. The memory side moves either one byte or one 16-bit word per accepted transfer.

The block raises a memory access request from the FIFO fill level and a programmable threshold. It keeps sticky overrun and underrun flags. Two frame events gate the request:
- the first request of a received frame waits until the address bytes have collected;
- a transmit starts with a prefetch of exactly the threshold amount, and the block then holds off until the start-of-frame delimiter has gone out.

A diagnostic port shows the oldest held byte, but only in loopback mode. Address matching, bus arbitration and DMA address counters are outside this block.

Top module: `nic_dma_fifo`

## Requirements
- R1: `thrSel` encodes the threshold as 0→2, 1→4, 2→8 and 3→12 bytes. In byte mode, the request asserts once the fill level reaches threshold+1, after the first request of a frame has been served.
- R2: In word mode (`wordMode`=1), the request point is the threshold plus 2 bytes.
- R3: An accepted memory transfer (`memReq` and `memAck` high in the same cycle) takes two bytes in word mode, with the older byte on `memWrData[7:0]`. In byte mode it takes one byte, with `memWrData[15:8]` zero. In receive, the request drops as soon as the level is below the request point.
- R4: In receive, after reset or after a `frameStart` pulse, the first request waits for a level of at least the larger of 8 and the request point.
- R5: In receive, writing a byte while 12 bytes are held (the 13th byte) sets `overrun`. `overrun` stays set until `clrFlags` is pulsed.
- R6: In transmit, a `frameStart` pulse makes the block request until exactly threshold bytes have been fetched. Bytes leave on `netDataOut` in arrival order, and a word's bits 7:0 go out before bits 15:8.
- R7: After the prefetch, no request is raised until `txSfdSent` is pulsed. After that, a refill request is raised while the level plus the request point is at most 13.
- R8: In transmit, a network strobe while the FIFO is empty sets `underrun`, which is sticky until `clrFlags`, and `netDataOut` reads 0.
- R9: `fifoPeek` shows the oldest held byte while `loopback` is 1, and reads 0 otherwise.
- R10: After reset, `memReq`, `overrun`, `underrun` and `fifoPeek` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirTx | input | 1 | 1 = transmit direction, 0 = receive |
| wordMode | input | 1 | 1 = 16-bit memory transfers, 0 = byte transfers |
| thrSel | input | 2 | Threshold select |
| frameStart | input | 1 | Receive: new frame seen; transmit: begin prefetch |
| txSfdSent | input | 1 | Transmit start-of-frame delimiter has been sent |
| netStrobe | input | 1 | Network byte strobe (push in receive, pop in transmit) |
| netDataIn | input | 8 | Received network byte |
| netDataOut | output | 8 | Byte toward the network |
| memAck | input | 1 | Memory side accepts a transfer this cycle |
| memRdData | input | 16 | Data read from buffer memory (transmit) |
| memWrData | output | 16 | Data to write to buffer memory (receive) |
| memReq | output | 1 | Buffer memory access request |
| clrFlags | input | 1 | Clears the sticky flags |
| loopback | input | 1 | Diagnostic loopback mode enable |
| fifoPeek | output | 8 | Diagnostic view of the oldest byte |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench probes each request point from both sides, one byte below and exactly at it:
- A design that used the programmed threshold without the one-byte or two-byte offset would request early.
- A design that ignored the frame gate would request at 5 bytes instead of 8 on a new receive frame.

It counts prefetch transfers, so a design that fetched one extra transfer, or that refilled before the delimiter was sent, is caught. The scoreboard checks byte order across words, so swapped halves show up. The overrun test writes exactly 12 and then 13 bytes, which catches a flag tied to a full FIFO instead of the 13th byte.

// File: rtl/nic_fifo_pkg.sv
package nic_fifo_pkg;

  // Strobes from control to datapath: bytes written, their source, bytes read.
  typedef struct packed {
    logic [1:0] wrNum;
    logic       wrFromMem;
    logic [1:0] rdNum;
  } fifoCmd_t;

  typedef enum logic [1:0] {TX_IDLE, TX_PREFETCH, TX_WAIT, TX_RUN} txPhase_t;

  function automatic logic [3:0] thrBytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/nic_fifo_dp.sv
module nic_fifo_dp
  import nic_fifo_pkg::*;
#(
  parameter  int DEPTH  = 16,   // power of two
  parameter  int BYTE_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoCmd_t            cmd,
  input  logic                wordMode,
  input  logic                loopback,
  input  logic [BYTE_W-1:0]   netDataIn,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic [LVL_W-1:0]    level,
  output logic [BYTE_W-1:0]   netDataOut,
  output logic [2*BYTE_W-1:0] memWrData,
  output logic [BYTE_W-1:0]   fifoPeek
);

  logic [BYTE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [BYTE_W-1:0] headByte, nextByte;

  always_ff @(posedge clk) begin
    if (cmd.wrNum != 2'd0)
      store[wrPtr] <= cmd.wrFromMem ? memRdData[BYTE_W-1:0] : netDataIn;
    if (cmd.wrNum == 2'd2)
      store[wrPtr + PTR_W'(1)] <= memRdData[2*BYTE_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(cmd.wrNum);
      rdPtr <= rdPtr + PTR_W'(cmd.rdNum);
      level <= level + LVL_W'(cmd.wrNum) - LVL_W'(cmd.rdNum);
    end
  end

  assign headByte   = store[rdPtr];
  assign nextByte   = store[rdPtr + PTR_W'(1)];
  assign netDataOut = (level == '0) ? '0 : headByte;
  assign memWrData  = wordMode ? {nextByte, headByte} : {{BYTE_W{1'b0}}, headByte};
  assign fifoPeek   = (loopback && level != '0) ? headByte : '0;

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  a_r3_read_held: assert property (@(posedge clk) disable iff (!rstN)
    LVL_W'(cmd.rdNum) <= level);

endmodule

// File: rtl/nic_fifo_ctrl.sv
module nic_fifo_ctrl
  import nic_fifo_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int OVR_LVL   = 13,
  parameter  int FIRST_LVL = 8,
  localparam int LVL_W     = $clog2(DEPTH + 1),
  localparam int CMP_W     = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirTx,
  input  logic             wordMode,
  input  logic [1:0]       thrSel,
  input  logic             frameStart,
  input  logic             txSfdSent,
  input  logic             netStrobe,
  input  logic             memAck,
  input  logic             clrFlags,
  input  logic [LVL_W-1:0] level,
  output fifoCmd_t         cmd,
  output logic             memReq,
  output logic             overrun,
  output logic             underrun
);

  txPhase_t         phase;
  logic             firstPend;
  logic [CMP_W-1:0] fetched, thr, point, firstPoint, lvl, xferBytes;
  logic             rxReq, txPre, txRefill, xfer, ovrSet, udrSet;

  always_comb begin
    lvl        = CMP_W'(level);
    thr        = CMP_W'(thrBytes(thrSel));
    xferBytes  = wordMode ? CMP_W'(2) : CMP_W'(1);
    point      = thr + (wordMode ? CMP_W'(2) : CMP_W'(1));
    firstPoint = (point > CMP_W'(FIRST_LVL)) ? point : CMP_W'(FIRST_LVL);
    rxReq      = !dirTx && (lvl >= (firstPend ? firstPoint : point));
    txPre      = dirTx && (phase == TX_PREFETCH) && (fetched < thr);
    txRefill   = dirTx && (phase == TX_RUN) && (lvl + point <= CMP_W'(OVR_LVL));
    memReq     = rxReq || txPre || txRefill;
    xfer       = memReq && memAck;

    cmd.wrFromMem = dirTx;
    if (dirTx) begin
      cmd.wrNum = xfer ? xferBytes[1:0] : 2'd0;
      cmd.rdNum = (netStrobe && level != '0) ? 2'd1 : 2'd0;
    end else begin
      cmd.wrNum = (netStrobe && lvl < CMP_W'(DEPTH)) ? 2'd1 : 2'd0;
      cmd.rdNum = xfer ? xferBytes[1:0] : 2'd0;
    end

    ovrSet = !dirTx && netStrobe && (lvl >= CMP_W'(OVR_LVL - 1));
    udrSet = dirTx && netStrobe && (level == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPend <= 1'b1;
      phase     <= TX_IDLE;
      fetched   <= '0;
      overrun   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      overrun  <= ovrSet || (overrun && !clrFlags);
      underrun <= udrSet || (underrun && !clrFlags);

      if (!dirTx && frameStart)  firstPend <= 1'b1;
      else if (!dirTx && xfer)   firstPend <= 1'b0;

      if (dirTx && frameStart) begin
        phase   <= TX_PREFETCH;
        fetched <= '0;
      end else begin
        case (phase)
          TX_PREFETCH: if (xfer) begin
            fetched <= fetched + xferBytes;
            if (fetched + xferBytes >= thr) phase <= TX_WAIT;
          end
          TX_WAIT: if (txSfdSent) phase <= TX_RUN;
          default: ;
        endcase
      end
    end
  end

  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rstN)
    (!dirTx && netStrobe && level == LVL_W'(OVR_LVL - 1)) |=> overrun);
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrFlags) |=> overrun);
  a_r8_udr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrFlags) |=> underrun);
  a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (dirTx && phase == TX_WAIT) |-> !memReq);
  a_r4_first_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!dirTx && firstPend && lvl < CMP_W'(FIRST_LVL)) |-> !memReq);
  a_r3_rx_enough: assert property (@(posedge clk) disable iff (!rstN)
    (!dirTx && memReq) |-> lvl >= CMP_W'(3));

endmodule

// File: rtl/nic_dma_fifo.sv
module nic_dma_fifo
  import nic_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dirTx,
  input  logic                wordMode,
  input  logic [1:0]          thrSel,
  input  logic                frameStart,
  input  logic                txSfdSent,
  input  logic                netStrobe,
  input  logic [BYTE_W-1:0]   netDataIn,
  output logic [BYTE_W-1:0]   netDataOut,
  input  logic                memAck,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic [2*BYTE_W-1:0] memWrData,
  output logic                memReq,
  input  logic                clrFlags,
  input  logic                loopback,
  output logic [BYTE_W-1:0]   fifoPeek,
  output logic                overrun,
  output logic                underrun
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  fifoCmd_t         cmd;
  logic [LVL_W-1:0] level;

  nic_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .wordMode(wordMode), .thrSel(thrSel),
    .frameStart(frameStart), .txSfdSent(txSfdSent), .netStrobe(netStrobe),
    .memAck(memAck), .clrFlags(clrFlags), .level(level), .cmd(cmd),
    .memReq(memReq), .overrun(overrun), .underrun(underrun)
  );

  nic_fifo_dp #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wordMode(wordMode), .loopback(loopback),
    .netDataIn(netDataIn), .memRdData(memRdData), .level(level),
    .netDataOut(netDataOut), .memWrData(memWrData), .fifoPeek(fifoPeek)
  );

endmodule

// File: tb/test_nic_dma_fifo.sv
module test_nic_dma_fifo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dirTx = 1'b0, wordMode = 1'b0, frameStart = 1'b0, txSfdSent = 1'b0;
  logic        netStrobe = 1'b0, memAck = 1'b0, clrFlags = 1'b0, loopback = 1'b0;
  logic [1:0]  thrSel = 2'd0;
  logic [7:0]  netDataIn = '0;
  logic [15:0] memRdData = '0;
  logic [7:0]  netDataOut, fifoPeek;
  logic [15:0] memWrData;
  logic        memReq, overrun, underrun;

  int checks = 0;
  int failures = 0;
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];

  always #10 clk = ~clk;

  nic_dma_fifo i_nic_dma_fifo (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .wordMode(wordMode), .thrSel(thrSel),
    .frameStart(frameStart), .txSfdSent(txSfdSent), .netStrobe(netStrobe),
    .netDataIn(netDataIn), .netDataOut(netDataOut), .memAck(memAck),
    .memRdData(memRdData), .memWrData(memWrData), .memReq(memReq),
    .clrFlags(clrFlags), .loopback(loopback), .fifoPeek(fifoPeek),
    .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: compares data crossing the edge with queued expectations.
  always @(posedge clk) begin
    if (rstN) begin
      if (!dirTx && memReq && memAck) begin
        logic [15:0] exp;
        if (wordMode) begin
          exp = {rxQ[1], rxQ[0]};
          void'(rxQ.pop_front());
          void'(rxQ.pop_front());
        end else begin
          exp = {8'h00, rxQ.pop_front()};
        end
        chk("R3 rx memory data", memWrData, exp);
      end
      if (dirTx && netStrobe) begin
        logic [7:0] expB;
        expB = (txQ.size() != 0) ? txQ.pop_front() : 8'h00;
        chk("R6/R8 tx byte order", {8'h00, netDataOut}, {8'h00, expB});
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    {frameStart, txSfdSent, netStrobe, memAck, clrFlags, loopback} = '0;
    rxQ.delete();
    txQ.delete();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic rxPush(input logic [7:0] b);
    netStrobe = 1'b1; netDataIn = b; rxQ.push_back(b);
    @(negedge clk); netStrobe = 1'b0; #1;
  endtask

  task automatic memXfer(input logic [15:0] d);
    memAck = 1'b1; memRdData = d;
    if (dirTx) begin
      txQ.push_back(d[7:0]);
      if (wordMode) txQ.push_back(d[15:8]);
    end
    @(negedge clk); memAck = 1'b0; #1;
  endtask

  task automatic netPop();
    netStrobe = 1'b1;
    @(negedge clk); netStrobe = 1'b0; #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk); s = 1'b0; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    @(negedge clk);
    doReset();
    chk("R10 reset memReq", {15'd0, memReq}, 16'd0);
    chk("R10 reset overrun", {15'd0, overrun}, 16'd0);
    chk("R10 reset underrun", {15'd0, underrun}, 16'd0);
    chk("R10 reset peek", {8'd0, fifoPeek}, 16'd0);

    // Receive, byte mode, 4-byte threshold: first gate at 8, then at 5.
    dirTx = 0; wordMode = 0; thrSel = 2'd1;
    for (int i = 0; i < 7; i++) rxPush(8'h10 + 8'(i));
    chk("R4 first request held at 7", {15'd0, memReq}, 16'd0);
    rxPush(8'h17);
    chk("R4 first request at 8", {15'd0, memReq}, 16'd1);
    loopback = 1'b1; #1;
    chk("R9 peek in loopback", {8'd0, fifoPeek}, 16'h0010);
    loopback = 1'b0; #1;
    chk("R9 peek hidden", {8'd0, fifoPeek}, 16'd0);
    n = 0;
    while (memReq && n < 20) begin memXfer(16'h0); n++; end
    chk("R3 byte drain stops below 5", 16'(n), 16'd4);
    rxPush(8'h18);
    chk("R1 byte-mode point threshold+1", {15'd0, memReq}, 16'd1);
    pulse(frameStart);
    chk("R4 new frame re-gates", {15'd0, memReq}, 16'd0);

    // Receive, word mode, 2-byte threshold: point 4, first gate 8.
    doReset();
    dirTx = 0; wordMode = 1; thrSel = 2'd0;
    for (int i = 0; i < 7; i++) rxPush(8'h40 + 8'(i));
    chk("R4 word first held at 7", {15'd0, memReq}, 16'd0);
    rxPush(8'h47);
    chk("R4 word first at 8", {15'd0, memReq}, 16'd1);
    n = 0;
    while (memReq && n < 20) begin memXfer(16'h0); n++; end
    chk("R3 word drain count", 16'(n), 16'd3);
    rxPush(8'h48);
    chk("R2 word held at 3", {15'd0, memReq}, 16'd0);
    rxPush(8'h49);
    chk("R2 word point threshold+2", {15'd0, memReq}, 16'd1);
    memXfer(16'h0);

    // Overrun at the 13th byte, sticky until cleared.
    doReset();
    dirTx = 0; wordMode = 0; thrSel = 2'd3;
    for (int i = 0; i < 12; i++) rxPush(8'h80 + 8'(i));
    chk("R5 no overrun at 12", {15'd0, overrun}, 16'd0);
    rxPush(8'h8c);
    chk("R5 overrun at 13th byte", {15'd0, overrun}, 16'd1);
    idle(3);
    chk("R5 overrun sticky", {15'd0, overrun}, 16'd1);
    pulse(clrFlags);
    chk("R5 overrun cleared", {15'd0, overrun}, 16'd0);

    // Transmit, byte mode, 4-byte threshold.
    doReset();
    dirTx = 1; wordMode = 0; thrSel = 2'd1;
    idle(2);
    chk("R7 no request before start", {15'd0, memReq}, 16'd0);
    pulse(frameStart);
    n = 0;
    while (memReq && n < 20) begin memXfer({8'h55, 8'hA0 + 8'(n)}); n++; end
    chk("R6 prefetch equals threshold", 16'(n), 16'd4);
    idle(3);
    chk("R7 quiet until delimiter", {15'd0, memReq}, 16'd0);
    pulse(txSfdSent);
    chk("R7 refill after delimiter", {15'd0, memReq}, 16'd1);
    n = 0;
    while (memReq && n < 20) begin memXfer({8'h66, 8'hB0 + 8'(n)}); n++; end
    chk("R7 refill stops at level 9", 16'(n), 16'd5);
    for (int i = 0; i < 9; i++) netPop();
    chk("R8 no underrun while data held", {15'd0, underrun}, 16'd0);
    netPop();
    chk("R8 underrun on empty pop", {15'd0, underrun}, 16'd1);
    idle(2);
    chk("R8 underrun sticky", {15'd0, underrun}, 16'd1);
    pulse(clrFlags);
    chk("R8 underrun cleared", {15'd0, underrun}, 16'd0);

    // Transmit, word mode, 8-byte threshold: four word fetches.
    doReset();
    dirTx = 1; wordMode = 1; thrSel = 2'd2;
    pulse(frameStart);
    n = 0;
    while (memReq && n < 20) begin memXfer({8'hD0 + 8'(n), 8'hC0 + 8'(n)}); n++; end
    chk("R6 word prefetch count", 16'(n), 16'd4);
    netPop();
    netPop();
    netPop();

    idle(2);
    finishRun();
  end

endmodule